// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date in a small register file of ten byte-wide locations: seconds, minutes, hours, day of week, day of month, month and year, plus three plain storage bytes for alarm values. A one-cycle pulse on `tick_i` once per second advances the time. Seconds carry into minutes, minutes into hours, hours into the date fields, and so on up to the two-digit year. Day-of-month rollover follows the length of the current month. February has 29 days when the year is a multiple of four, which is correct for the years 2000 to 2099.

A host reads and writes the locations through a plain address/data port. The read is combinational and writes land on the clock edge. Three level inputs select how the values are kept. `binary_i` chooses packed BCD or plain binary, and the choice applies to both storage and counting. `h24_i` chooses 24-hour or 12-hour hours, with a PM flag in bit 7 of the hours byte in 12-hour mode. `hold_i` stops the once-per-second advance, so software can load a consistent new time without racing the counter.

Top module: `rtc_calendar`

## Requirements
- R1: After reset all ten locations read 0x00.
- R2: `rdata_o` shows the location selected by `addr_i` in the same cycle. Addresses 0 to 9 are: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year. Addresses 10 to 15 read 0x00, and writes to them have no effect.
- R3: A write (`wr_en_i` high at a clock edge) stores `wdata_i` into the addressed location, and the new value is readable after that edge. If a tick is taken in the same cycle, the write wins for that location and the other fields still advance.
- R4: While `hold_i` is 1, ticks change nothing. Writes still take effect.
- R5: On a tick taken with `hold_i` = 0, seconds advance by one at that clock edge. Seconds and minutes count 0 to 59. A wrap to 0 carries into the next field.
- R6: With `binary_i` = 0, every time and date byte is packed BCD (tens in bits 7:4, units in bits 3:0), so 0x09 steps to 0x10 and 0x59 steps to 0x00. With `binary_i` = 1, values are plain binary, so 0x09 steps to 0x0A and 0x3B steps to 0x00.
- R7: With `h24_i` = 1, hours count 0 to 23, and the step from 23 to 0 carries into the date fields.
- R8: With `h24_i` = 0, hours count 12, 1, ..., 11 in bits 6:0, and bit 7 is the PM flag. The step from 11 to 12 toggles PM. The step from 12 to 1 keeps PM. Only the step from 11 PM to 12 AM carries into the date fields. In BCD, 12 PM is 0x92.
- R9: Day of week counts 1 to 7, advances on each date carry, and wraps from 7 to 1.
- R10: Day of month wraps to 1 after the last day of the month and carries into the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year value is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R11: Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0.
- R12: Alarm locations 1, 3 and 5 change only by host writes, never by ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| hold_i | input | 1 | 1 suppresses the tick advance |
| binary_i | input | 1 | 1 = binary values, 0 = packed BCD |
| h24_i | input | 1 | 1 = 24-hour mode, 0 = 12-hour mode with PM in bit 7 |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Location index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
A write or a tick sampled at one rising edge is readable on `rdata_o` right after that edge. The full carry chain, from seconds through to the year, settles within that single edge. The read path is combinational, so a changed address gives its data in the same cycle. Each scenario task drives stimulus on the falling edge and holds it for one full period. It then checks on the next falling edge, after setting the address and waiting 1 ns, so every check sees exactly one elapsed rising edge.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int unsigned NUM_LOCS = 10;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned VAL_W    = 7;

  localparam int unsigned LOC_SEC     = 0;
  localparam int unsigned LOC_SEC_ALM = 1;
  localparam int unsigned LOC_MIN     = 2;
  localparam int unsigned LOC_MIN_ALM = 3;
  localparam int unsigned LOC_HR      = 4;
  localparam int unsigned LOC_HR_ALM  = 5;
  localparam int unsigned LOC_DOW     = 6;
  localparam int unsigned LOC_DOM     = 7;
  localparam int unsigned LOC_MON     = 8;
  localparam int unsigned LOC_YR      = 9;

  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam val_t SEC_MAX  = 7'd59;
  localparam val_t HR24_MAX = 7'd23;
  localparam val_t HR12_TOP = 7'd12;
  localparam val_t DOW_MAX  = 7'd7;
  localparam val_t MON_MAX  = 7'd12;
  localparam val_t YR_MAX   = 7'd99;

  // Binary view of the time fields; pm is meaningful in 12-hour mode only
  typedef struct packed {
    val_t sec;
    val_t min;
    val_t hr;
    logic pm;
    val_t dow;
    val_t dom;
    val_t mon;
    val_t yr;
  } tod_t;

  function automatic val_t to_bin(input byte_t b, input logic bin_mode);
    if (bin_mode) return b[VAL_W-1:0];
    return val_t'(b[7:4]) * val_t'(10) + val_t'(b[3:0]);
  endfunction

  function automatic byte_t from_bin(input val_t v, input logic bin_mode);
    val_t tens;
    val_t ones;
    if (bin_mode) return {1'b0, v};
    tens = v / val_t'(10);
    ones = v % val_t'(10);
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic val_t month_days(input val_t mon, input val_t yr);
    case (mon)
      7'd2:                   return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_decode.sv
`timescale 1ns/1ps
module rtc_decode
  import rtc_cal_pkg::*;
#(
  parameter int unsigned N = NUM_LOCS
) (
  input  logic [N-1:0][DATA_W-1:0] locs_i,
  input  logic                     binary_i,
  input  logic                     h24_i,
  output tod_t                     tod_o
);
  byte_t hr_raw;
  logic  unused_alarm_bits;

  assign hr_raw = h24_i ? locs_i[LOC_HR] : {1'b0, locs_i[LOC_HR][6:0]};
  assign unused_alarm_bits = ^{locs_i[LOC_SEC_ALM], locs_i[LOC_MIN_ALM], locs_i[LOC_HR_ALM]};

  always_comb begin
    tod_o.sec = to_bin(locs_i[LOC_SEC], binary_i);
    tod_o.min = to_bin(locs_i[LOC_MIN], binary_i);
    tod_o.hr  = to_bin(hr_raw, binary_i);
    tod_o.pm  = ~h24_i & locs_i[LOC_HR][7];
    tod_o.dow = to_bin(locs_i[LOC_DOW], binary_i);
    tod_o.dom = to_bin(locs_i[LOC_DOM], binary_i);
    tod_o.mon = to_bin(locs_i[LOC_MON], binary_i);
    tod_o.yr  = to_bin(locs_i[LOC_YR], binary_i);
  end
endmodule

// File: rtl/rtc_step.sv
`timescale 1ns/1ps
module rtc_step
  import rtc_cal_pkg::*;
(
  input  tod_t cur_i,
  input  logic h24_i,
  output tod_t nxt_o
);
  logic sec_c, min_c, day_c, dom_c, mon_c;

  always_comb begin
    nxt_o = cur_i;
    day_c = 1'b0;

    sec_c     = (cur_i.sec >= SEC_MAX);
    nxt_o.sec = sec_c ? '0 : cur_i.sec + 7'd1;

    min_c = 1'b0;
    if (sec_c) begin
      min_c     = (cur_i.min >= SEC_MAX);
      nxt_o.min = min_c ? '0 : cur_i.min + 7'd1;
    end

    if (min_c) begin
      if (h24_i) begin
        day_c    = (cur_i.hr >= HR24_MAX);
        nxt_o.hr = day_c ? '0 : cur_i.hr + 7'd1;
      end else if (cur_i.hr == HR12_TOP - 7'd1) begin
        nxt_o.hr = HR12_TOP;
        nxt_o.pm = ~cur_i.pm;
        day_c    = cur_i.pm;  // 11 PM -> 12 AM starts a new day
      end else if (cur_i.hr >= HR12_TOP) begin
        nxt_o.hr = 7'd1;
      end else begin
        nxt_o.hr = cur_i.hr + 7'd1;
      end
    end

    dom_c = 1'b0;
    mon_c = 1'b0;
    if (day_c) begin
      nxt_o.dow = (cur_i.dow >= DOW_MAX) ? 7'd1 : cur_i.dow + 7'd1;
      dom_c     = (cur_i.dom >= month_days(cur_i.mon, cur_i.yr));
      nxt_o.dom = dom_c ? 7'd1 : cur_i.dom + 7'd1;
    end
    if (dom_c) begin
      mon_c     = (cur_i.mon >= MON_MAX);
      nxt_o.mon = mon_c ? 7'd1 : cur_i.mon + 7'd1;
    end
    if (mon_c) begin
      nxt_o.yr = (cur_i.yr >= YR_MAX) ? '0 : cur_i.yr + 7'd1;
    end
  end
endmodule

// File: rtl/rtc_encode.sv
`timescale 1ns/1ps
module rtc_encode
  import rtc_cal_pkg::*;
#(
  parameter int unsigned N = NUM_LOCS
) (
  input  tod_t                     tod_i,
  input  logic [N-1:0][DATA_W-1:0] locs_i,
  input  logic                     binary_i,
  input  logic                     h24_i,
  output logic [N-1:0][DATA_W-1:0] locs_o
);
  byte_t hr_enc;

  assign hr_enc = from_bin(tod_i.hr, binary_i);

  always_comb begin
    locs_o          = locs_i;  // alarm bytes pass through untouched
    locs_o[LOC_SEC] = from_bin(tod_i.sec, binary_i);
    locs_o[LOC_MIN] = from_bin(tod_i.min, binary_i);
    locs_o[LOC_HR]  = h24_i ? hr_enc : {tod_i.pm, hr_enc[6:0]};
    locs_o[LOC_DOW] = from_bin(tod_i.dow, binary_i);
    locs_o[LOC_DOM] = from_bin(tod_i.dom, binary_i);
    locs_o[LOC_MON] = from_bin(tod_i.mon, binary_i);
    locs_o[LOC_YR]  = from_bin(tod_i.yr, binary_i);
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              binary_i,
  input  logic              h24_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_LOCS-1:0][DATA_W-1:0] locs_q;
  logic [NUM_LOCS-1:0][DATA_W-1:0] locs_adv;
  tod_t cur_tod, nxt_tod;
  logic adv;

  assign adv = tick_i & ~hold_i;

  rtc_decode #(.N(NUM_LOCS)) u_decode (
    .locs_i  (locs_q),
    .binary_i(binary_i),
    .h24_i   (h24_i),
    .tod_o   (cur_tod)
  );

  rtc_step u_step (
    .cur_i(cur_tod),
    .h24_i(h24_i),
    .nxt_o(nxt_tod)
  );

  rtc_encode #(.N(NUM_LOCS)) u_encode (
    .tod_i   (nxt_tod),
    .locs_i  (locs_q),
    .binary_i(binary_i),
    .h24_i   (h24_i),
    .locs_o  (locs_adv)
  );

  for (genvar g = 0; g < NUM_LOCS; g++) begin : g_loc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      locs_q[g] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(g))         locs_q[g] <= wdata_i;
      else if (adv)                                     locs_q[g] <= locs_adv[g];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_LOCS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = locs_q[i];
    end
  end

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(locs_q));

  a_r4_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !wr_en_i) |=> $stable(locs_q));

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i < ADDR_W'(NUM_LOCS)) |=> (locs_q[$past(addr_i)] == $past(wdata_i)));

  a_r5_sec_step_bin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !wr_en_i && binary_i && locs_q[LOC_SEC] < 8'd59)
      |=> (locs_q[LOC_SEC] == $past(locs_q[LOC_SEC]) + 8'd1));

  a_r12_alarm_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(locs_q[LOC_SEC_ALM]) && $stable(locs_q[LOC_MIN_ALM])
                  && $stable(locs_q[LOC_HR_ALM])));
endmodule

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, hold = 1'b0, bin = 1'b0, h24 = 1'b1, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hold_i(hold),
    .binary_i(bin), .h24_i(h24), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s: loc %0d got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic tick_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, dw, dm, mo, y);
    wr(0, s); wr(2, m); wr(4, h); wr(6, dw); wr(7, dm); wr(8, mo); wr(9, y);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 10; i++) chk(4'(i), 8'h00, "R1 reset");
  endtask

  task automatic t_port();
    wr(1, 8'h45); wr(3, 8'h17); wr(12, 8'hFF);
    @(negedge clk);
    chk(1, 8'h45, "R2 read alarm sec");
    chk(3, 8'h17, "R2 read alarm min");
    chk(12, 8'h00, "R2 high address reads zero");
    chk(0, 8'h00, "R2 high address write ignored");
  endtask

  task automatic t_bcd_sec();
    bin = 1'b0; h24 = 1'b1;
    set_all(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    tick1(); chk(0, 8'h10, "R5 R6 bcd 09->10");
    wr(0, 8'h59); tick1();
    chk(0, 8'h00, "R5 R6 bcd 59 wraps");
    chk(2, 8'h01, "R5 minute carry");
  endtask

  task automatic t_bin_sec();
    bin = 1'b1; h24 = 1'b1;
    set_all(8'h09, 8'h05, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    tick1(); chk(0, 8'h0A, "R6 binary 09->0A");
    wr(0, 8'h3B); tick1();
    chk(0, 8'h00, "R6 binary 59 wraps");
    chk(2, 8'h06, "R6 binary minute carry");
  endtask

  task automatic t_h24();
    bin = 1'b0; h24 = 1'b1;
    set_all(8'h59, 8'h59, 8'h09, 8'h03, 8'h10, 8'h05, 8'h21);
    tick1(); chk(4, 8'h10, "R7 hour 09->10");
    chk(7, 8'h10, "R7 no date carry");
    wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h23); tick1();
    chk(4, 8'h00, "R7 23 wraps");
    chk(7, 8'h11, "R7 date carry");
    chk(6, 8'h04, "R9 dow step");
  endtask

  task automatic t_h12();
    bin = 1'b0; h24 = 1'b0;
    set_all(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h05, 8'h21);
    tick1(); chk(4, 8'h92, "R8 11AM->12PM");
    chk(7, 8'h10, "R8 noon no date carry");
    wr(0, 8'h59); wr(2, 8'h59); tick1();
    chk(4, 8'h81, "R8 12PM->1PM");
    wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h91); tick1();
    chk(4, 8'h12, "R8 11PM->12AM");
    chk(7, 8'h11, "R8 midnight date carry");
    bin = 1'b1;
    set_all(8'd59, 8'd59, 8'd11, 8'd2, 8'd10, 8'd5, 8'd21);
    tick1(); chk(4, 8'h8C, "R8 binary 12PM");
    h24 = 1'b1;
  endtask

  task automatic t_dow();
    bin = 1'b0; h24 = 1'b1;
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h05, 8'h06, 8'h22);
    tick1(); chk(6, 8'h01, "R9 dow 7 wraps to 1");
  endtask

  task automatic t_month_len();
    bin = 1'b1; h24 = 1'b1;
    set_all(8'd59, 8'd59, 8'd23, 8'd1, 8'd30, 8'd4, 8'd22);
    tick1(); chk(7, 8'd1, "R10 30-day month wraps");
    chk(8, 8'd5, "R10 month carry");
    set_all(8'd59, 8'd59, 8'd23, 8'd1, 8'd30, 8'd5, 8'd22);
    tick1(); chk(7, 8'd31, "R10 31-day month reaches 31");
    bin = 1'b0;
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick1(); chk(7, 8'h29, "R10 leap Feb 29");
    wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h23); tick1();
    chk(7, 8'h01, "R10 leap Feb wraps after 29");
    chk(8, 8'h03, "R10 leap month carry");
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick1(); chk(7, 8'h01, "R10 common Feb wraps after 28");
    chk(8, 8'h03, "R10 common month carry");
  endtask

  task automatic t_year_end();
    bin = 1'b0; h24 = 1'b1;
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick1();
    chk(0, 8'h00, "R11 sec");
    chk(4, 8'h00, "R11 hour");
    chk(7, 8'h01, "R11 dom");
    chk(8, 8'h01, "R11 month wraps");
    chk(9, 8'h00, "R11 year 99 wraps");
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h41);
    tick1(); chk(9, 8'h42, "R11 year step");
  endtask

  task automatic t_hold();
    bin = 1'b0; h24 = 1'b1;
    set_all(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    hold = 1'b1;
    tick1(); chk(0, 8'h20, "R4 hold freezes seconds");
    wr(2, 8'h33); chk(2, 8'h33, "R4 write during hold");
    hold = 1'b0;
    tick1(); chk(0, 8'h21, "R4 resumes after hold");
  endtask

  task automatic t_override();
    bin = 1'b0; h24 = 1'b1;
    set_all(8'h05, 8'h10, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    tick_wr(0, 8'h30); chk(0, 8'h30, "R3 write beats tick");
    wr(0, 8'h59);
    tick_wr(2, 8'h20);
    chk(0, 8'h00, "R3 other field advances");
    chk(2, 8'h20, "R3 written minute kept");
  endtask

  task automatic t_alarm_kept();
    wr(1, 8'h45); wr(3, 8'h17); wr(5, 8'h08);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    tick1();
    chk(1, 8'h45, "R12 alarm sec kept");
    chk(3, 8'h17, "R12 alarm min kept");
    chk(5, 8'h08, "R12 alarm hr kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_port();
    t_bcd_sec();
    t_bin_sec();
    t_h24();
    t_h12();
    t_dow();
    t_month_len();
    t_year_end();
    t_hold();
    t_override();
    t_alarm_kept();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule